// File: doc/BRIEF.md
# Three-Register Dual-Read File

This block stores the working registers of a small 8-bit accumulator-style CPU. It has an accumulator and two index registers, X and Y. Two combinational read ports supply the left and right ALU operands, and each port has its own 2-bit select. A single write port captures the ALU result on the rising clock edge.

The write select also serves as the write enable. Code 0 leaves every register untouched, so the block needs no separate enable pin. Each read port routes exactly one source to its output. A read select of 0 yields a zero operand.

Top module: `trio_regfile`

## Requirements
- R1: A high `rst` at a rising clock edge clears the accumulator, X and Y to 0x00. Reset is synchronous and active-high, and it takes priority over any write in that cycle.
- R2: With `wr_sel` = 1 at a rising edge, the accumulator takes `wr_data`. X and Y are unchanged.
- R3: With `wr_sel` = 2 at a rising edge, X takes `wr_data`. With `wr_sel` = 3, Y takes `wr_data`. The other two registers are unchanged in each case.
- R4: With `wr_sel` = 0 at a rising edge, all three registers keep their values, whatever `wr_data` holds.
- R5: `lop` shows the accumulator when `lsel` = 1, X when `lsel` = 2 and Y when `lsel` = 3. The output follows the select within the same cycle.
- R6: `rop` uses the same code mapping as R5, driven by `rsel`. It is independent of `lsel`.
- R7: A read select of 0 drives 0x00 on that operand port.
- R8: When `lsel` equals `rsel`, `lop` and `rop` carry the same value.
- R9: In the cycle a register is being written, both read ports still return its old value. The new value appears only after the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_sel | input | 2 | Write target: 0 none, 1 accumulator, 2 X, 3 Y |
| wr_data | input | 8 | ALU result to be written |
| lsel | input | 2 | Left operand select: 0 zero, 1 accumulator, 2 X, 3 Y |
| rsel | input | 2 | Right operand select, same codes as `lsel` |
| lop | output | 8 | Left ALU operand |
| rop | output | 8 | Right ALU operand |

## Verification
Operand reads are due in the same cycle as their select, with zero register stages on the path. Writes are due one rising edge after `wr_sel` and `wr_data` are presented. The bench changes inputs on the falling edge and compares `lop` and `rop` one time unit later. Each read check therefore sees the register contents from before the coming edge, which is what R9 requires. The bench updates its own model only after that edge, so a write is checked by the reads in the following cycle.

// File: rtl/trio_regfile.sv
module trio_regfile #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    lsel,
  input  logic [1:0]    rsel,
  output logic [DW-1:0] lop,
  output logic [DW-1:0] rop
);

  localparam logic [1:0] SEL_NONE = 2'd0;
  localparam logic [1:0] SEL_ACC  = 2'd1;
  localparam logic [1:0] SEL_X    = 2'd2;
  localparam logic [1:0] SEL_Y    = 2'd3;

  logic [DW-1:0] acc_q, x_q, y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
    end else begin
      if (wr_sel == SEL_ACC) acc_q <= wr_data;
      if (wr_sel == SEL_X)   x_q   <= wr_data;
      if (wr_sel == SEL_Y)   y_q   <= wr_data;
    end
  end

  function automatic logic [DW-1:0] pick(input logic [1:0] s,
                                         input logic [DW-1:0] a,
                                         input logic [DW-1:0] x,
                                         input logic [DW-1:0] y);
    case (s)
      SEL_ACC: pick = a;
      SEL_X:   pick = x;
      SEL_Y:   pick = y;
      default: pick = '0;
    endcase
  endfunction

  assign lop = pick(lsel, acc_q, x_q, y_q);
  assign rop = pick(rsel, acc_q, x_q, y_q);

endmodule

// File: rtl/trio_regfile_chk.sv
module trio_regfile_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    wr_sel,
  input logic [DW-1:0] wr_data,
  input logic [1:0]    lsel,
  input logic [1:0]    rsel,
  input logic [DW-1:0] lop,
  input logic [DW-1:0] rop,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] x_q,
  input logic [DW-1:0] y_q
);

  a_r2_acc_write: assert property (@(posedge clk) disable iff (rst)
    wr_sel == 2'd1 |=> acc_q == $past(wr_data) && $stable(x_q) && $stable(y_q));

  a_r3_x_write: assert property (@(posedge clk) disable iff (rst)
    wr_sel == 2'd2 |=> x_q == $past(wr_data) && $stable(acc_q) && $stable(y_q));

  a_r3_y_write: assert property (@(posedge clk) disable iff (rst)
    wr_sel == 2'd3 |=> y_q == $past(wr_data) && $stable(acc_q) && $stable(x_q));

  a_r4_no_write: assert property (@(posedge clk) disable iff (rst)
    wr_sel == 2'd0 |=> $stable(acc_q) && $stable(x_q) && $stable(y_q));

  a_r7_zero_left: assert property (@(posedge clk) disable iff (rst)
    lsel == 2'd0 |-> lop == '0);

  a_r7_zero_right: assert property (@(posedge clk) disable iff (rst)
    rsel == 2'd0 |-> rop == '0);

  a_r8_same_sel: assert property (@(posedge clk) disable iff (rst)
    lsel == rsel |-> lop == rop);

endmodule

bind trio_regfile trio_regfile_chk #(.DW(DW)) chk_i (.*);

// File: tb/trio_regfile_tb_top.sv
module trio_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] lsel = '0;
  logic [1:0] rsel = '0;
  logic [7:0] lop, rop;

  logic [7:0] mdl [0:3];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  trio_regfile dut_i (.clk(clk), .rst(rst), .wr_sel(wr_sel), .wr_data(wr_data),
                      .lsel(lsel), .rsel(rsel), .lop(lop), .rop(rop));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] expect_rd(input logic [1:0] s);
    return (s == 2'd0) ? 8'h00 : mdl[s];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cycle(input string tag, input logic r, input logic [1:0] ws,
                       input logic [7:0] wd, input logic [1:0] ls, input logic [1:0] rs);
    @(negedge clk);
    rst = r; wr_sel = ws; wr_data = wd; lsel = ls; rsel = rs;
    #1;
    if (!r) begin
      check({tag, " left"}, lop, expect_rd(ls));
      check({tag, " right"}, rop, expect_rd(rs));
    end
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    end else if (ws != 2'd0) begin
      mdl[ws] = wd;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    cycle("R1 reset", 1'b1, 2'd1, 8'hAA, 2'd1, 2'd2);
    cycle("R1 reset state acc/x", 1'b0, 2'd0, 8'h00, 2'd1, 2'd2);
    cycle("R1 reset state y", 1'b0, 2'd0, 8'h00, 2'd3, 2'd3);
    cycle("R2 write acc", 1'b0, 2'd1, 8'h11, 2'd0, 2'd0);
    cycle("R3 write x, R9 old acc", 1'b0, 2'd2, 8'h22, 2'd1, 2'd2);
    cycle("R3 write y, R9 old y", 1'b0, 2'd3, 8'h33, 2'd2, 2'd3);
    cycle("R5 R6 acc/y", 1'b0, 2'd0, 8'hFF, 2'd1, 2'd3);
    cycle("R4 code0 ignored", 1'b0, 2'd0, 8'h5A, 2'd0, 2'd0);
    for (int l = 0; l < 4; l++)
      for (int r = 0; r < 4; r++)
        cycle("R5 R6 R7 R8 all selects", 1'b0, 2'd0, 8'hC3, l[1:0], r[1:0]);
    cycle("R9 acc write pending", 1'b0, 2'd1, 8'h99, 2'd1, 2'd1);
    cycle("R9 acc now new", 1'b0, 2'd0, 8'h00, 2'd1, 2'd0);
    cycle("R1 reset beats write", 1'b1, 2'd2, 8'h77, 2'd0, 2'd0);
    cycle("R1 cleared x", 1'b0, 2'd0, 8'h00, 2'd2, 2'd1);
    for (int i = 0; i < 400; i++) begin
      logic [1:0] ws, ls, rs;
      logic [7:0] wd;
      ws = 2'($urandom);
      wd = 8'($urandom);
      ls = 2'($urandom);
      rs = 2'($urandom);
      cycle("R2 R3 R4 R5 R6 R9 random", 1'b0, ws, wd, ls, rs);
    end
    cycle("R8 same select", 1'b0, 2'd0, 8'h00, 2'd2, 2'd2);
    finish_run();
  end
endmodule